// File: doc/BRIEF.md
# Serial Receiver Configuration Port with Gain Decode

This block is a write-only serial slave that holds the tuning and volume settings of a direct-sampling receiver. A controller frames a transfer by pulling the active-low select low, clocks a 32-bit word in most significant bit first on rising serial-clock edges, and then releases select. When select rises, the block copies the word into the active settings. Until that moment, the settings already in use stay in force.

The low 26 bits of the word become the oscillator phase increment. Bits 29 down to 26 are a gain code. The block turns that code into a left-shift amount for the audio path. Codes 0 to 4 give shifts 0 to 4. Every larger code saturates at shift 5, which is a gain of x32. Bits 31 and 30 are don't-care.

All three serial lines are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and edges are found in the system clock domain. For that reason the system clock must run several times faster than the serial clock.

Top module: `rx_cfg_spi`

## Requirements
- R1: After reset, `phase_inc` is 0 and `gain_shift` is 0.
- R2: After a full 32-bit frame is sent with bit 31 first, `phase_inc` equals bits 25..0 of that word.
- R3: Gain codes 0, 1, 2, 3 and 4 in bits 29..26 give `gain_shift` values 0, 1, 2, 3 and 4.
- R4: Every gain code from 5 to 15 gives `gain_shift` = 5, and `gain_shift` never exceeds 5.
- R5: Bits 31..30 of the word have no effect on either output.
- R6: While `spi_csn` is low, the outputs keep the values from the previous frame, even after some or all bits of the new word have been shifted in.
- R7: New settings appear on the outputs exactly 3 rising `clk` edges after `spi_csn` goes high at the pins (synchroniser plus edge detector), and not earlier.
- R8: Rising `spi_sck` edges while `spi_csn` is high shift nothing. A later frame with zero clock edges therefore recaptures the last word unchanged.
- R9: If a rising `spi_sck` edge and the rising edge of `spi_csn` are detected in the same system cycle, that final bit is shifted in and is part of the captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, asynchronous; data is sampled on its rising edge |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_csn | input | 1 | Active-low frame select; its rising edge commits the word |
| phase_inc | output | 26 | Active oscillator phase increment |
| gain_shift | output | 3 | Active audio left-shift amount (0 to 5) |

## Verification
Two events can fall in the same system cycle: the shift of the last serial bit and the commit triggered by the rising edge of select. The bench provokes this by raising `spi_sck` and `spi_csn` on the same clock phase, so the synchronisers deliver both edges in one cycle. It then judges the outcome against a behavioural model, which requires the shifted bit to be part of the committed word. The final bit of that word differs from the bit the register held before, so dropping the last bit produces a visible mismatch in `phase_inc`.

// File: rtl/rx_cfg_pkg.sv
package rx_cfg_pkg;

   // Default geometry of the configuration word
   localparam int CFG_WORD_W    = 32;
   localparam int CFG_INC_W     = 26;
   localparam int CFG_GAIN_W    = 4;
   localparam int CFG_MAX_SHIFT = 5;
   localparam int CFG_SYNC      = 2;

   // Idle levels of the serial lines, used as synchroniser reset values
   localparam logic SCK_IDLE = 1'b0;
   localparam logic CSN_IDLE = 1'b1;
   localparam logic DAT_IDLE = 1'b0;

endpackage

// File: rtl/rx_cfg_sync.sv
module rx_cfg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("rx_cfg_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL}};
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];

endmodule

// File: rtl/rx_cfg_shifter.sv
module rx_cfg_shifter #(
   parameter int KEEP_W = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              csn_s,
   output logic [KEEP_W-1:0] word_q
);

   generate
      if (KEEP_W < 2) begin : g_bad_keep
         $error("rx_cfg_shifter needs at least two retained bits");
      end
   endgenerate

   logic              sck_q;
   logic              csn_q;
   logic              sck_rise;
   logic              cs_rise;
   logic              shift_en;
   logic [KEEP_W-1:0] sr_q;
   logic [KEEP_W-1:0] sr_next;

   // Previous synchronised levels for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= rx_cfg_pkg::SCK_IDLE;
         csn_q <= rx_cfg_pkg::CSN_IDLE;
      end else begin
         sck_q <= sck_s;
         csn_q <= csn_s;
      end
   end

   assign sck_rise = sck_s & ~sck_q;
   assign cs_rise  = csn_s & ~csn_q;
   // Gate on the previous select level so a last bit that meets the
   // closing select edge is still taken.
   assign shift_en = sck_rise & ~csn_q;

   always_comb begin
      sr_next = sr_q;
      if (shift_en) sr_next = {sr_q[KEEP_W-2:0], mosi_s};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         word_q <= '0;
      end else begin
         sr_q <= sr_next;
         if (cs_rise) word_q <= sr_next;
      end
   end

   // R2
   shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_rise && !csn_q) |=> (sr_q[0] == $past(mosi_s)));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csn_q && csn_s) |=> $stable(sr_q));

   // R6
   no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_rise |=> $stable(word_q));

   // R9
   edge_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && sck_rise) |=> (word_q[0] == $past(mosi_s)));

endmodule

// File: rtl/rx_cfg_gain_dec.sv
module rx_cfg_gain_dec #(
   parameter int CODE_W    = 4,
   parameter int MAX_SHIFT = 5,
   parameter int SH_W      = 3,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   output logic [SH_W-1:0]   shift
);

   generate
      if (MAX_SHIFT >= (1 << SH_W)) begin : g_bad_sh_w
         $error("rx_cfg_gain_dec shift width too small for MAX_SHIFT");
      end
   endgenerate

   logic [SH_W-1:0] sat;

   // Power-of-two gain: code is the shift, clipped at MAX_SHIFT
   always_comb begin
      if (int'(code) >= MAX_SHIFT) sat = SH_W'(MAX_SHIFT);
      else                         sat = SH_W'(code);
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shift <= '0;
            else        shift <= sat;
         end
      end else begin : g_comb
         assign shift = sat;
      end
   endgenerate

   // R4
   shift_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(shift) <= MAX_SHIFT);

endmodule

// File: rtl/rx_cfg_spi.sv
module rx_cfg_spi #(
   parameter int WORD_W      = rx_cfg_pkg::CFG_WORD_W,
   parameter int INC_W       = rx_cfg_pkg::CFG_INC_W,
   parameter int GAIN_W      = rx_cfg_pkg::CFG_GAIN_W,
   parameter int MAX_SHIFT   = rx_cfg_pkg::CFG_MAX_SHIFT,
   parameter int SYNC_STAGES = rx_cfg_pkg::CFG_SYNC,
   parameter bit SHIFT_REG   = 1'b0,
   localparam int SH_W       = $clog2(MAX_SHIFT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spi_sck,
   input  logic             spi_mosi,
   input  logic             spi_csn,
   output logic [INC_W-1:0] phase_inc,
   output logic [SH_W-1:0]  gain_shift
);

   localparam int KEEP_W = INC_W + GAIN_W;

   generate
      if (KEEP_W > WORD_W) begin : g_bad_split
         $error("rx_cfg_spi fields do not fit the serial word");
      end
      if (MAX_SHIFT < 1) begin : g_bad_max
         $error("rx_cfg_spi MAX_SHIFT must be positive");
      end
   endgenerate

   logic              sck_s;
   logic              mosi_s;
   logic              csn_s;
   logic [KEEP_W-1:0] word_q;

   rx_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(rx_cfg_pkg::SCK_IDLE)) i_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(spi_sck), .q(sck_s));

   rx_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(rx_cfg_pkg::DAT_IDLE)) i_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s));

   rx_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(rx_cfg_pkg::CSN_IDLE)) i_sync_csn (
      .clk(clk), .rst_n(rst_n), .d(spi_csn), .q(csn_s));

   // Only the low KEEP_W bits can reach the settings; the top bits of a
   // frame simply fall off the end of the shorter register.
   rx_cfg_shifter #(.KEEP_W(KEEP_W)) i_shifter (
      .clk(clk), .rst_n(rst_n),
      .sck_s(sck_s), .mosi_s(mosi_s), .csn_s(csn_s),
      .word_q(word_q));

   rx_cfg_gain_dec #(
      .CODE_W(GAIN_W), .MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W), .OUT_REG(SHIFT_REG)
   ) i_gain_dec (
      .clk(clk), .rst_n(rst_n),
      .code(word_q[KEEP_W-1:INC_W]),
      .shift(gain_shift));

   assign phase_inc = word_q[INC_W-1:0];

   // R6
   csn_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_csn && !$past(spi_csn) && !csn_s) |=> $stable(phase_inc));

endmodule

// File: tb/test_rx_cfg_spi.sv
`timescale 1ns/1ps
module test_rx_cfg_spi;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        mosi = 1'b0;
   logic        csn = 1'b1;
   logic [25:0] phase_inc;
   logic [2:0]  gain_shift;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rx_cfg_spi i_rx_cfg_spi (
      .clk(clk), .rst_n(rst_n),
      .spi_sck(sck), .spi_mosi(mosi), .spi_csn(csn),
      .phase_inc(phase_inc), .gain_shift(gain_shift));

   function automatic int exp_sh(int code);
      return (code >= 5) ? 5 : code;
   endfunction

   // Behavioural reference: line histories in queues, 32-bit word model
   bit          h_sck[$];
   bit          h_cs[$];
   bit          h_dat[$];
   logic [31:0] m_sr;
   logic [31:0] m_hold;

   always @(posedge clk) begin
      bit sck_edge;
      bit cs_edge;
      if (!rst_n) begin
         h_sck = '{0, 0, 0};
         h_cs  = '{1, 1, 1};
         h_dat = '{0, 0, 0};
         m_sr = 0;
         m_hold = 0;
      end else begin
         sck_edge = h_sck[1] && !h_sck[2];
         cs_edge  = h_cs[1] && !h_cs[2];
         if (sck_edge && !h_cs[2]) m_sr = {m_sr[30:0], h_dat[1]};
         if (cs_edge) m_hold = m_sr;
         h_sck.push_front(sck); void'(h_sck.pop_back());
         h_cs.push_front(csn);  void'(h_cs.pop_back());
         h_dat.push_front(mosi); void'(h_dat.pop_back());
      end
   end

   // R7: cycle-accurate comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         tests++;
         if (phase_inc !== m_hold[25:0] || int'(gain_shift) != exp_sh(int'(m_hold[29:26]))) begin
            fails++;
            $display("FAIL R7 model: phase_inc=%h shift=%0d, expected %h shift=%0d",
                     phase_inc, gain_shift, m_hold[25:0], exp_sh(int'(m_hold[29:26])));
         end
      end
   end

   task automatic summary_and_end();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000 && !done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
         summary_and_end();
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string tag, logic [25:0] ei, int es);
      tests++;
      if (phase_inc !== ei || int'(gain_shift) != es) begin
         fails++;
         $display("FAIL %s: phase_inc=%h shift=%0d, expected %h shift=%0d",
                  tag, phase_inc, gain_shift, ei, es);
      end
   endtask

   task automatic frame_open();
      csn = 1'b0;
      tick(4);
   endtask

   task automatic put_bits(logic [31:0] w, int hi, int lo);
      for (int b = hi; b >= lo; b--) begin
         mosi = w[b];
         tick(3);
         sck = 1'b1;
         tick(3);
         sck = 1'b0;
      end
   endtask

   task automatic frame_close();
      tick(3);
      csn = 1'b1;
      tick(6);
   endtask

   task automatic send(logic [31:0] w);
      frame_open();
      put_bits(w, 31, 0);
      frame_close();
   endtask

   initial begin
      logic [31:0] w;
      tick(4);
      rst_n = 1'b1;
      tick(2);
      chk("R1 reset", 26'h0, 0);

      send(32'h0C132B55);
      chk("R2 word", 26'h0132B55, 3);

      for (int c = 0; c < 16; c++) begin
         w = {2'b01, 4'(c), 26'h15A5A5};
         send(w);
         if (c < 5) chk("R3 gain", 26'h15A5A5, c);
         else       chk("R4 gain sat", 26'h15A5A5, 5);
      end

      send(32'hC0000000 | (32'd2 << 26) | 32'h2AAAAAA);
      chk("R5 top bits set", 26'h2AAAAAA, 2);
      send((32'd2 << 26) | 32'h2AAAAAA);
      chk("R5 top bits clear", 26'h2AAAAAA, 2);

      // R6: partial and complete shifting with select still low
      w = {2'b00, 4'd1, 26'h0ABCDEF};
      frame_open();
      put_bits(w, 31, 16);
      chk("R6 half frame", 26'h2AAAAAA, 2);
      put_bits(w, 15, 0);
      tick(4);
      chk("R6 full bits select low", 26'h2AAAAAA, 2);
      frame_close();
      chk("R6 committed", 26'h0ABCDEF, 1);

      // R8: clock activity with select high, then an empty frame
      mosi = 1'b1;
      repeat (10) begin
         tick(3);
         sck = 1'b1;
         tick(3);
         sck = 1'b0;
      end
      tick(4);
      chk("R8 idle clocks", 26'h0ABCDEF, 1);
      frame_open();
      frame_close();
      chk("R8 empty frame", 26'h0ABCDEF, 1);

      // R7: commit latency of three clock edges
      w = {2'b10, 4'd4, 26'h1234567};
      frame_open();
      put_bits(w, 31, 0);
      tick(3);
      csn = 1'b1;
      tick(2);
      chk("R7 two edges", 26'h0ABCDEF, 1);
      tick(1);
      chk("R7 three edges", 26'h1234567, 4);
      tick(6);

      // R9: last clock edge coincides with select release
      w = {2'b00, 4'd6, 26'h3000001};
      frame_open();
      put_bits(w, 31, 1);
      mosi = w[0];
      tick(3);
      sck = 1'b1;
      csn = 1'b1;
      tick(6);
      sck = 1'b0;
      tick(4);
      chk("R9 coincident edges", 26'h3000001, 5);

      done = 1'b1;
      summary_and_end();
   end

endmodule